// File: doc/BRIEF.md
# Synchronous DRAM Write Burst Path

This block is the device-side write path of a two-bank, 16-bit synchronous DRAM. On every clock it decodes the active-low command pins. It turns a WRITE command into a run of per-beat array write strobes. Each strobe carries the target bank, the column, the data word and a byte-lane enable for each of the two byte lanes. The column sequence is sequential. For fixed lengths it wraps inside the burst-aligned block. For full-page length it runs around the whole 256-column row and goes on until it is stopped.

The burst length comes from a small configuration register, which is loaded with a mode-load command. A burst ends in one of three ways: it runs out, a BURST TERMINATE cuts it short, or a new WRITE replaces it. The data word present in the terminate clock is never stored. Per-byte mask inputs suppress individual lanes, or a whole beat, while the column sequence keeps advancing. Downstream storage consumes the registered strobe outputs.

Top module: `sdr_wpath`

## Requirements
- R1: Commands are decoded from {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n}. 0100 is WRITE, 0110 is BURST TERMINATE and 0000 is MODE LOAD. Any other pattern, and any clock with chip_sel_n high, starts nothing and stops nothing.
- R2: MODE LOAD stores col_in[2:0] as the burst-length code: 0→1, 1→2, 2→4, 3→8, 7→full page. Codes 4, 5 and 6 act as length 1. After reset the code is 0.
- R3: The first beat uses the data, bank_in and col_in of the WRITE clock itself. Each beat sampled at a clock edge appears on the arr_* outputs right after that same edge.
- R4: For fixed lengths, beat k writes column (start & ~(L-1)) | ((start + k) & (L-1)). The burst then ends on its own after L beats.
- R5: In full-page mode, beat k writes column (start + k) mod 256. The burst continues without limit.
- R6: BURST TERMINATE during a burst stores nothing in its own clock, and no further beat of that burst is stored. The last stored element is therefore the one from the clock before.
- R7: BURST TERMINATE also ends a full-page burst.
- R8: byte_mask_in[0] masks wdata_in[7:0] and byte_mask_in[1] masks wdata_in[15:8]. arr_lane_en is the inverse of the mask for a beat. arr_we is high only when at least one lane is enabled. A fully masked beat still uses up its column.
- R9: A WRITE that arrives during a burst ends the old burst and starts the new one in that same clock.
- R10: A burst keeps the length and bank captured at its WRITE. A MODE LOAD during a burst neither stops it nor changes its length, and it applies to the next WRITE.
- R11: During and straight after reset, arr_we and arr_lane_en are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low command select |
| row_strobe_n | input | 1 | Command pin, row strobe (active low) |
| col_strobe_n | input | 1 | Command pin, column strobe (active low) |
| wr_en_n | input | 1 | Command pin, write enable (active low) |
| bank_in | input | 1 | Bank selected by a WRITE |
| col_in | input | 8 | Start column of a WRITE; bits 2:0 give the length code on MODE LOAD |
| wdata_in | input | 16 | Write data of the current clock |
| byte_mask_in | input | 2 | Per-lane mask, high suppresses the lane |
| arr_we | output | 1 | Array write strobe |
| arr_bank | output | 1 | Bank of the write |
| arr_col | output | 8 | Column of the write |
| arr_data | output | 16 | Data of the write |
| arr_lane_en | output | 2 | Byte-lane enables of the write |

## Verification
The bench drives bursts of each fixed length. Start columns are chosen off the block boundary so that a wrong wrap shows up as a wrong column. A full-page burst runs past 256 beats, which shows whether it wraps around the row or stops. Terminates land on the first, a middle and the last beat of a burst, which tells dropping the terminate-clock word apart from dropping the word before it. Masked beats sit next to terminates, a restart goes to the other bank, and a mode load arrives mid-burst. Together these separate per-burst latching of length and bank from live use of the configuration register.

// File: rtl/sdr_wpath_pkg.sv
package sdr_wpath_pkg;
  localparam int COL_W  = 8;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int BANK_W = 1;
  localparam int CODE_W = 3;
  localparam int LG_W   = 2;

  typedef enum logic [1:0] {CMD_IDLE, CMD_WRITE, CMD_TERM, CMD_MODE} cmd_e;

  typedef struct packed {
    logic            full;
    logic [LG_W-1:0] lg;
  } blen_t;

  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_IDLE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b100:  c = CMD_WRITE;
        3'b110:  c = CMD_TERM;
        3'b000:  c = CMD_MODE;
        default: c = CMD_IDLE;
      endcase
    end
    return c;
  endfunction

  function automatic blen_t code_to_blen(input logic [CODE_W-1:0] code);
    blen_t b;
    b.full = 1'b0;
    b.lg   = '0;
    case (code)
      3'd1:    b.lg = 2'd1;
      3'd2:    b.lg = 2'd2;
      3'd3:    b.lg = 2'd3;
      3'd7:    b.full = 1'b1;
      default: b.lg = '0;
    endcase
    return b;
  endfunction

  function automatic logic [COL_W-1:0] blk_mask(input blen_t b);
    logic [COL_W-1:0] one;
    one = 1;
    return b.full ? '1 : ((one << b.lg) - one);
  endfunction

  function automatic logic [COL_W-1:0] col_for_beat(input logic [COL_W-1:0] base,
                                                    input logic [COL_W-1:0] idx,
                                                    input blen_t b);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] s;
    m = blk_mask(b);
    s = base + idx;
    return (base & ~m) | (s & m);
  endfunction
endpackage

// File: rtl/sdr_wpath_decode.sv
module sdr_wpath_decode
  import sdr_wpath_pkg::*;
(
  input  logic chip_sel_n,
  input  logic row_strobe_n,
  input  logic col_strobe_n,
  input  logic wr_en_n,
  output logic is_write,
  output logic is_term,
  output logic is_mode
);
  cmd_e cmd;

  always_comb begin
    cmd      = decode_pins(chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n);
    is_write = (cmd == CMD_WRITE);
    is_term  = (cmd == CMD_TERM);
    is_mode  = (cmd == CMD_MODE);
  end
endmodule

// File: rtl/sdr_wpath_mode.sv
module sdr_wpath_mode
  import sdr_wpath_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] code,
  output blen_t         mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode <= code_to_blen('0);
    else if (load) mode <= code_to_blen(code);
  end
endmodule

// File: rtl/sdr_wpath_burst.sv
module sdr_wpath_burst
  import sdr_wpath_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_write,
  input  logic          is_term,
  input  blen_t         mode,
  input  logic [BW-1:0] bank_in,
  input  logic [CW-1:0] col_in,
  output logic          beat_valid,
  output logic [BW-1:0] beat_bank,
  output logic [CW-1:0] beat_col,
  output logic          burst_live
);
  logic          live_q;
  logic [CW-1:0] base_q;
  logic [CW-1:0] idx_q;
  blen_t         blen_q;
  logic [BW-1:0] bank_q;
  logic          cont_beat;
  logic          last_beat;
  logic          term_hit;

  assign cont_beat  = live_q && !is_write && !is_term;
  assign term_hit   = live_q && is_term && !is_write;
  assign last_beat  = !blen_q.full && (idx_q == blk_mask(blen_q));
  assign burst_live = live_q;

  always_comb begin
    beat_valid = is_write || cont_beat;
    beat_col   = is_write ? col_in  : col_for_beat(base_q, idx_q, blen_q);
    beat_bank  = is_write ? bank_in : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      blen_q <= code_to_blen('0);
      bank_q <= '0;
    end else if (is_write) begin
      live_q <= mode.full || (mode.lg != '0);
      base_q <= col_in;
      idx_q  <= CW'(1);
      blen_q <= mode;
      bank_q <= bank_in;
    end else if (live_q) begin
      if (is_term) begin
        live_q <= 1'b0;
      end else begin
        idx_q <= idx_q + CW'(1);
        if (last_beat) live_q <= 1'b0;
      end
    end
  end

  // R4
  fixed_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !blen_q.full) |-> (idx_q <= blk_mask(blen_q)));

  // R6
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> !live_q);

  // R5
  full_page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && blen_q.full) ##1 cont_beat |-> (beat_col == $past(beat_col) + CW'(1)));

  // R9
  restart_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && live_q) |-> (beat_valid && beat_col == col_in));
endmodule

// File: rtl/sdr_wpath_beat_out.sv
module sdr_wpath_beat_out
  import sdr_wpath_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int BW = BANK_W,
  parameter int DW = DATA_W,
  parameter int LW = LANE_W,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic [BW-1:0] beat_bank,
  input  logic [CW-1:0] beat_col,
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] mask,
  output logic          arr_we,
  output logic [BW-1:0] arr_bank,
  output logic [CW-1:0] arr_col,
  output logic [DW-1:0] arr_data,
  output logic [NL-1:0] arr_lane_en
);
  logic any_lane;
  assign any_lane = (mask != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we   <= 1'b0;
      arr_bank <= '0;
      arr_col  <= '0;
    end else begin
      arr_we <= beat_valid && any_lane;
      if (beat_valid) begin
        arr_bank <= beat_bank;
        arr_col  <= beat_col;
      end
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arr_lane_en[l]           <= 1'b0;
        arr_data[l*LW +: LW]     <= '0;
      end else begin
        arr_lane_en[l] <= beat_valid && !mask[l];
        if (beat_valid) arr_data[l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  // R8
  strobe_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ($countones(arr_lane_en) > 0));

  // R8
  masked_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !any_lane) |=> (!arr_we && arr_lane_en == '0));
endmodule

// File: rtl/sdr_wpath.sv
module sdr_wpath
  import sdr_wpath_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int BW = BANK_W,
  parameter int DW = DATA_W,
  parameter int LW = LANE_W,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_sel_n,
  input  logic          row_strobe_n,
  input  logic          col_strobe_n,
  input  logic          wr_en_n,
  input  logic [BW-1:0] bank_in,
  input  logic [CW-1:0] col_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [NL-1:0] byte_mask_in,
  output logic          arr_we,
  output logic [BW-1:0] arr_bank,
  output logic [CW-1:0] arr_col,
  output logic [DW-1:0] arr_data,
  output logic [NL-1:0] arr_lane_en
);
  logic          is_write;
  logic          is_term;
  logic          is_mode;
  blen_t         mode;
  logic          beat_valid;
  logic [BW-1:0] beat_bank;
  logic [CW-1:0] beat_col;
  logic          burst_live;

  sdr_wpath_decode u_decode (
    .chip_sel_n   (chip_sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .is_write     (is_write),
    .is_term      (is_term),
    .is_mode      (is_mode)
  );

  sdr_wpath_mode #(.CW(CODE_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (is_mode),
    .code  (col_in[CODE_W-1:0]),
    .mode  (mode)
  );

  sdr_wpath_burst #(.CW(CW), .BW(BW)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_write   (is_write),
    .is_term    (is_term),
    .mode       (mode),
    .bank_in    (bank_in),
    .col_in     (col_in),
    .beat_valid (beat_valid),
    .beat_bank  (beat_bank),
    .beat_col   (beat_col),
    .burst_live (burst_live)
  );

  sdr_wpath_beat_out #(.CW(CW), .BW(BW), .DW(DW), .LW(LW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_valid  (beat_valid),
    .beat_bank   (beat_bank),
    .beat_col    (beat_col),
    .wdata       (wdata_in),
    .mask        (byte_mask_in),
    .arr_we      (arr_we),
    .arr_bank    (arr_bank),
    .arr_col     (arr_col),
    .arr_data    (arr_data),
    .arr_lane_en (arr_lane_en)
  );

  // R3
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && byte_mask_in != '1) |=>
      (arr_we && arr_col == $past(col_in) && arr_data == $past(wdata_in)
       && arr_bank == $past(bank_in)));

  // R6
  term_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_term && !is_write) |=> !arr_we);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_live && !is_write) |=> (!arr_we && arr_lane_en == '0));
endmodule

// File: tb/sdr_wpath_bench.sv
module sdr_wpath_bench;
  localparam int C_NOP = 0, C_WR = 1, C_BT = 2, C_LM = 3, C_INH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1, row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1;
  logic [0:0]  bank_in = '0;
  logic [7:0]  col_in = '0;
  logic [15:0] wdata_in = '0;
  logic [1:0]  byte_mask_in = '0;
  logic        arr_we;
  logic [0:0]  arr_bank;
  logic [7:0]  arr_col;
  logic [15:0] arr_data;
  logic [1:0]  arr_lane_en;

  always #5 clk = ~clk;

  sdr_wpath u_sdr_wpath (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .row_strobe_n(row_strobe_n),
    .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n), .bank_in(bank_in), .col_in(col_in),
    .wdata_in(wdata_in), .byte_mask_in(byte_mask_in), .arr_we(arr_we), .arr_bank(arr_bank),
    .arr_col(arr_col), .arr_data(arr_data), .arr_lane_en(arr_lane_en)
  );

  typedef struct {
    bit          we;
    bit          bank;
    logic [7:0]  col;
    logic [15:0] data;
    logic [1:0]  lane;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0, n_bad = 0, n_cyc = 0;
  int mode_len = 1;
  bit m_act = 0, m_bank = 0;
  int m_base = 0, m_idx = 0, m_len = 1;
  logic [15:0] dval = 16'h1000;

  function automatic int code_len(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int model_col(input int base, input int idx, input int len);
    if (len == 0) return (base + idx) % 256;
    return (base / len) * len + ((base % len) + idx) % len;
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic cyc(input int c, input bit ba, input int col, input logic [1:0] m,
                     input string tag);
    exp_t e;
    bit beat;
    int bcol;
    @(negedge clk);
    dval = dval + 16'h0101;
    case (c)
      C_WR:  {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 4'b0100;
      C_BT:  {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 4'b0110;
      C_LM:  {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 4'b0000;
      C_INH: {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 4'b1100;
      default: {chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 4'b0111;
    endcase
    bank_in = ba; col_in = col[7:0]; wdata_in = dval; byte_mask_in = m;
    beat = 0; bcol = 0;
    if (c == C_WR) begin
      beat = 1; bcol = col; m_bank = ba; m_base = col; m_idx = 1;
      m_len = mode_len; m_act = (mode_len != 1);
    end else if (m_act && c == C_BT) begin
      m_act = 0;
    end else if (m_act) begin
      beat = 1; bcol = model_col(m_base, m_idx, m_len);
      m_idx++;
      if (m_len != 0 && m_idx == m_len) m_act = 0;
    end
    if (c == C_LM) mode_len = code_len(col % 8);
    e.we = beat && (m != 2'b11);
    e.bank = m_bank; e.col = bcol[7:0]; e.data = dval;
    e.lane = beat ? ~m : 2'b00;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rst_n && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_vec++;
      if (arr_we !== e.we || arr_lane_en !== e.lane) begin
        n_bad++;
        $display("FAIL %s: we/lane=%0b/%b expected %0b/%b", e.tag, arr_we, arr_lane_en, e.we, e.lane);
      end else if (e.we && (arr_bank !== e.bank || arr_col !== e.col || arr_data !== e.data)) begin
        n_bad++;
        $display("FAIL %s: bank/col/data=%0d/%h/%h expected %0d/%h/%h", e.tag,
                 arr_bank, arr_col, arr_data, e.bank, e.col, e.data);
      end
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL R3 watchdog: cycles=%0d expected<=%0d", n_cyc, 150000);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    n_vec++;
    if (arr_we !== 1'b0 || arr_lane_en !== 2'b00) begin
      n_bad++;
      $display("FAIL R11: we/lane=%0b/%b expected 0/00", arr_we, arr_lane_en);
    end
    rst_n = 1'b1;
    // R11 nothing stored after reset without a WRITE; R2 default length 1
    cyc(C_NOP, 0, 0, 2'b00, "R11");
    cyc(C_WR, 1, 8'h42, 2'b00, "R3");
    cyc(C_NOP, 0, 0, 2'b00, "R2");
    cyc(C_NOP, 0, 0, 2'b00, "R2");
    // R1 inhibited write and unused pattern start nothing
    cyc(C_INH, 0, 8'h10, 2'b00, "R1");
    cyc(C_NOP, 0, 0, 2'b00, "R1");
    // R4 length 2 and 4 with wrap
    cyc(C_LM, 0, 1, 2'b00, "R2");
    cyc(C_WR, 0, 8'h11, 2'b00, "R4");
    cyc(C_NOP, 0, 0, 2'b00, "R4");
    cyc(C_NOP, 0, 0, 2'b00, "R4");
    cyc(C_LM, 0, 2, 2'b00, "R2");
    cyc(C_WR, 1, 8'h06, 2'b00, "R4");
    for (int i = 0; i < 5; i++) cyc(C_NOP, 0, 0, 2'b00, "R4");
    // R4 length 8, chip deselect inside burst does not stop it (R1)
    cyc(C_LM, 0, 3, 2'b00, "R2");
    cyc(C_WR, 0, 8'h3D, 2'b00, "R4");
    cyc(C_INH, 0, 0, 2'b00, "R1");
    for (int i = 0; i < 7; i++) cyc(C_NOP, 0, 0, 2'b00, "R4");
    // R6 terminate in first beat (beat index 1)
    cyc(C_WR, 0, 8'h20, 2'b00, "R6");
    cyc(C_BT, 0, 0, 2'b00, "R6");
    for (int i = 0; i < 3; i++) cyc(C_NOP, 0, 0, 2'b00, "R6");
    // R6 terminate mid-burst with masked beats next to it (R8)
    cyc(C_WR, 1, 8'h50, 2'b00, "R6");
    cyc(C_NOP, 0, 0, 2'b01, "R8");
    cyc(C_NOP, 0, 0, 2'b10, "R8");
    cyc(C_NOP, 0, 0, 2'b11, "R8");
    cyc(C_BT, 0, 0, 2'b00, "R6");
    for (int i = 0; i < 4; i++) cyc(C_NOP, 0, 0, 2'b00, "R6");
    // R6 terminate on the last beat of a length-4 burst
    cyc(C_LM, 0, 2, 2'b00, "R2");
    cyc(C_WR, 0, 8'h87, 2'b00, "R6");
    cyc(C_NOP, 0, 0, 2'b00, "R6");
    cyc(C_NOP, 0, 0, 2'b11, "R8");
    cyc(C_BT, 0, 0, 2'b00, "R6");
    cyc(C_NOP, 0, 0, 2'b00, "R6");
    // R9 restart into the other bank
    cyc(C_WR, 0, 8'h90, 2'b00, "R9");
    cyc(C_NOP, 0, 0, 2'b00, "R9");
    cyc(C_WR, 1, 8'hA2, 2'b01, "R9");
    for (int i = 0; i < 5; i++) cyc(C_NOP, 0, 0, 2'b00, "R9");
    // R10 mode load mid-burst; R2 reserved code acts as length 1
    cyc(C_LM, 0, 3, 2'b00, "R2");
    cyc(C_WR, 1, 8'hC4, 2'b00, "R10");
    cyc(C_NOP, 0, 0, 2'b00, "R10");
    cyc(C_LM, 0, 5, 2'b00, "R10");
    for (int i = 0; i < 7; i++) cyc(C_NOP, 0, 0, 2'b00, "R10");
    cyc(C_WR, 0, 8'hC4, 2'b00, "R2");
    cyc(C_NOP, 0, 0, 2'b00, "R2");
    cyc(C_NOP, 0, 0, 2'b00, "R2");
    // R5 full page wraps across the row; R7 terminate ends it
    cyc(C_LM, 0, 7, 2'b00, "R2");
    cyc(C_WR, 1, 8'hFD, 2'b00, "R5");
    for (int i = 0; i < 262; i++) cyc(C_NOP, 0, 0, (i % 37 == 5) ? 2'b11 : 2'b00, "R5");
    cyc(C_NOP, 0, 0, 2'b10, "R8");
    cyc(C_BT, 0, 0, 2'b00, "R7");
    for (int i = 0; i < 4; i++) cyc(C_NOP, 0, 0, 2'b00, "R7");
    @(negedge clk);
    @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: pending=%0d expected 0", exp_q.size());
    end
    report();
    $finish;
  end
endmodule